// File: doc/BRIEF.md
# Addressed Serial Control Register Port

This block is a synchronous serial slave that lets a host reach a small bank of 10-bit control registers. It generates the serial bit clock itself by dividing the master clock by a programmable rate. Every frame is a 16-bit word. The host drives the word on `sdi_i`, and `fs_i` is high during the first bit. At the same time the block shifts a 16-bit word out on `sdo_o`.

A frame's upper six bits select a register and its lower ten bits carry the value to write. Reads are indirect. The host writes a register address into the pointer register, and each following frame returns the pointer and the value of the register it selects. The control registers are grouped. Each group has a control word whose top bit clears the whole group. The pointer and rate registers are cleared only by the reset pin. All group register bits are driven on `regs_o` for use by neighbouring logic.

Top module: `csp_ctrl_port`

## Requirements
- R1: A word is 16 bits, sent MSB first. Bits 15:10 are the address and bits 9:0 are the data. `sdi_i` is sampled on rising edges of `sclk_o`, and `fs_i` is high at the edge that samples bit 15. A write to group g, register k (address 8g+k, g in 0..1, k in 0..3) appears on `regs_o[(4g+k)*10 +: 10]`.
- R2: During each frame `sdo_o` carries `{ptr[5:0], value[9:0]}`, MSB first. Here ptr is the pointer register (address 62) at the start of the frame. `sdo_o` changes only after falling edges of `sclk_o`, and bit 15 becomes valid at the rising edge that follows the framing edge.
- R3: A register written in one frame can be read back in the next frame.
- R4: `sclk_o` is high and low for `rate` master clocks each, where `rate` is the register at address 63. A rate of 0 acts as 1. The reset rate is 4, which gives a period of 8 master clocks.
- R5: Writing a group control word (address 8g) with bit 9 set clears every register of that group within 4 master clocks. Bit 9 then reads back as 0, and the other group is untouched.
- R6: A group clear leaves the pointer and rate registers unchanged.
- R7: After `rst_ni` is released, the block holds for 8 master clocks. With the default rate, `sclk_o` stays low until it first rises on the 12th master clock edge after release.
- R8: After reset, all group registers and the pointer are 0 and `sdo_o` is 0.
- R9: A write to an undefined address changes no register. A read of an undefined address returns data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_i | input | 1 | Frame sync, high during the first bit |
| sdi_i | input | 1 | Serial data from host |
| sclk_o | output | 1 | Generated serial bit clock |
| sdo_o | output | 1 | Serial data to host |
| regs_o | output | 80 | Group registers, 10 bits each, register 0 of group 0 lowest |

## Verification
The assertions assume the host changes `fs_i` and `sdi_i` only while `sclk_o` is low. They also assume frames are long enough that a group clear finishes before the next write arrives. The bench drives every bit a moment after a falling edge of `sclk_o`. It leaves one idle bit between frames, so each 16-bit word completes before the next frame sync. A behavioural model keeps the register contents, the pointer and the rate, and predicts each frame's readout.

// File: rtl/ctl_sport_pkg.sv
package ctl_sport_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 10;
  localparam int WORD_W = ADDR_W + DATA_W;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/csp_sclk_div.sv
module csp_sclk_div
  import ctl_sport_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  data_t half_i,
  output logic  sclk_o,
  output logic  rise_o,
  output logic  fall_o
);
  data_t cnt_q, half;
  logic  sclk_q, tick;

  assign half   = (half_i == '0) ? data_t'(1) : half_i;
  assign tick   = !hold_i && (cnt_q >= half - data_t'(1));
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q  <= cnt_q + data_t'(1);
    end
  end
endmodule

// File: rtl/csp_frame_shift.sv
module csp_frame_shift
  import ctl_sport_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  fs_i,
  input  logic  sdi_i,
  input  word_t tx_word_i,
  output logic  sdo_o,
  output logic  wr_o,
  output word_t wr_word_o
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  word_t            in_q, out_q, word_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= '0; out_q <= '0; word_q <= '0;
      cnt_q <= '0; pend_q <= 1'b0; wr_q <= 1'b0;
    end else if (hold_i) begin
      in_q <= '0; out_q <= '0; word_q <= '0;
      cnt_q <= '0; pend_q <= 1'b0; wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (rise_i) begin
        if (fs_i) begin
          in_q   <= {in_q[WORD_W-2:0], sdi_i};
          cnt_q  <= CNT_W'(1);
          pend_q <= 1'b1;
        end else if (cnt_q != '0) begin
          in_q <= {in_q[WORD_W-2:0], sdi_i};
          if (cnt_q == CNT_W'(WORD_W-1)) begin
            cnt_q  <= '0;
            wr_q   <= 1'b1;
            word_q <= {in_q[WORD_W-2:0], sdi_i};
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
      if (fall_i) begin
        if (pend_q) begin
          out_q  <= tx_word_i;
          pend_q <= 1'b0;
        end else begin
          out_q <= {out_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o     = out_q[WORD_W-1];
  assign wr_o      = wr_q;
  assign wr_word_o = word_q;

  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i && !hold_i |=> $stable(sdo_o)); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o); // R1
endmodule

// File: rtl/csp_reg_bank.sv
module csp_reg_bank
  import ctl_sport_pkg::*;
#(
  parameter int GRP_N      = 2,
  parameter int GRP_REGS   = 4,
  parameter int GRP_STRIDE = 8,
  parameter int SRST_BIT   = 9,
  parameter int SRST_CLKS  = 4,
  parameter int PTR_ADDR   = 62,
  parameter int RATE_ADDR  = 63,
  parameter int RATE_RST   = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              hold_i,
  input  logic                              wr_i,
  input  word_t                             wr_word_i,
  output logic [GRP_N*GRP_REGS*DATA_W-1:0]  regs_o,
  output data_t                             rate_o,
  output word_t                             tx_word_o
);
  localparam int STR_L = $clog2(GRP_STRIDE);
  localparam int SC_W  = $clog2(SRST_CLKS);
  localparam int GW    = GRP_REGS * DATA_W;

  addr_t wr_addr;
  data_t wr_data, rd_data;
  addr_t ptr_q;
  data_t rate_q;
  logic  addr_def;

  assign wr_addr = wr_word_i[WORD_W-1:DATA_W];
  assign wr_data = wr_word_i[DATA_W-1:0];

  for (genvar g = 0; g < GRP_N; g++) begin : gen_grp
    logic [GW-1:0]   r_q;
    logic [SC_W-1:0] sc_q;
    logic            hit, srst_hit;
    logic [STR_L-1:0] idx;

    assign idx      = wr_addr[STR_L-1:0];
    assign hit      = wr_i && (wr_addr[ADDR_W-1:STR_L] == (ADDR_W-STR_L)'(g))
                      && (idx < STR_L'(GRP_REGS));
    assign srst_hit = hit && (idx == '0) && wr_data[SRST_BIT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0; sc_q <= '0;
      end else if (hold_i) begin
        r_q <= '0; sc_q <= '0;
      end else if (srst_hit) begin
        r_q <= '0; sc_q <= SC_W'(SRST_CLKS-1);
      end else if (sc_q != '0) begin
        r_q <= '0; sc_q <= sc_q - SC_W'(1);
      end else if (hit) begin
        for (int k = 0; k < GRP_REGS; k++)
          if (idx == STR_L'(k)) r_q[k*DATA_W +: DATA_W] <= wr_data;
      end
    end

    assign regs_o[g*GW +: GW] = r_q;

    AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_hit && !hold_i |=> r_q == '0); // R5
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0; rate_q <= data_t'(RATE_RST);
    end else if (hold_i) begin
      ptr_q <= '0; rate_q <= data_t'(RATE_RST);
    end else if (wr_i) begin
      if (wr_addr == addr_t'(PTR_ADDR))  ptr_q  <= wr_data[ADDR_W-1:0];
      if (wr_addr == addr_t'(RATE_ADDR)) rate_q <= wr_data;
    end
  end

  always_comb begin
    rd_data  = '0;
    addr_def = (wr_addr == addr_t'(PTR_ADDR)) || (wr_addr == addr_t'(RATE_ADDR));
    for (int g = 0; g < GRP_N; g++)
      for (int k = 0; k < GRP_REGS; k++) begin
        if (ptr_q == addr_t'(g*GRP_STRIDE + k)) rd_data = regs_o[(g*GRP_REGS+k)*DATA_W +: DATA_W];
        if (wr_addr == addr_t'(g*GRP_STRIDE + k)) addr_def = 1'b1;
      end
    if (ptr_q == addr_t'(PTR_ADDR))  rd_data = data_t'(ptr_q);
    if (ptr_q == addr_t'(RATE_ADDR)) rd_data = rate_q;
  end

  assign rate_o    = rate_q;
  assign tx_word_o = {ptr_q, rd_data};

  AST_SRST_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !hold_i && (wr_addr[STR_L-1:0] == '0) && wr_data[SRST_BIT] && addr_def
    && (wr_addr != addr_t'(PTR_ADDR)) && (wr_addr != addr_t'(RATE_ADDR))
    |=> $stable(ptr_q) && $stable(rate_q)); // R6
  AST_UNDEF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !hold_i && !addr_def |=> $stable(regs_o) && $stable(ptr_q) && $stable(rate_q)); // R9
endmodule

// File: rtl/csp_ctrl_port.sv
module csp_ctrl_port
  import ctl_sport_pkg::*;
#(
  parameter int GRP_N    = 2,
  parameter int GRP_REGS = 4,
  parameter int POR_CLKS = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             fs_i,
  input  logic                             sdi_i,
  output logic                             sclk_o,
  output logic                             sdo_o,
  output logic [GRP_N*GRP_REGS*DATA_W-1:0] regs_o
);
  localparam int POR_W = $clog2(POR_CLKS + 1);

  logic [POR_W-1:0] por_q;
  logic  hold, rise, fall, wr;
  word_t wr_word, tx_word;
  data_t rate;

  assign hold = (por_q != POR_W'(POR_CLKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   por_q <= '0;
    else if (hold) por_q <= por_q + POR_W'(1);
  end

  csp_sclk_div u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .half_i(rate),
    .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
  );

  csp_frame_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .rise_i(rise), .fall_i(fall),
    .fs_i(fs_i), .sdi_i(sdi_i), .tx_word_i(tx_word),
    .sdo_o(sdo_o), .wr_o(wr), .wr_word_o(wr_word)
  );

  csp_reg_bank #(.GRP_N(GRP_N), .GRP_REGS(GRP_REGS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .wr_i(wr), .wr_word_i(wr_word),
    .regs_o(regs_o), .rate_o(rate), .tx_word_o(tx_word)
  );

  AST_HOLD_NO_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> !sclk_o); // R7
endmodule

// File: tb/csp_ctrl_port_test.sv
`timescale 1ns/1ps
module csp_ctrl_port_test;
  logic clk_i = 1'b0, rst_ni = 1'b0, fs_i = 1'b0, sdi_i = 1'b0;
  logic sclk_o, sdo_o;
  logic [79:0] regs_o;
  int errs = 0, checks = 0;
  bit done = 0;
  int mg [2][4];
  int mptr = 0, mrate = 4;

  always #4 clk_i = !clk_i;

  csp_ctrl_port uut (.clk_i(clk_i), .rst_ni(rst_ni), .fs_i(fs_i), .sdi_i(sdi_i),
                     .sclk_o(sclk_o), .sdo_o(sdo_o), .regs_o(regs_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mread(int a);
    if (a < 16 && (a % 8) < 4) return mg[a/8][a%8];
    if (a == 62) return mptr;
    if (a == 63) return mrate;
    return 0;
  endfunction

  function automatic void mwrite(int a, int d);
    if (a < 16 && (a % 8) < 4) begin
      if ((a % 8) == 0 && d[9]) for (int k = 0; k < 4; k++) mg[a/8][k] = 0;
      else mg[a/8][a%8] = d;
    end else if (a == 62) mptr = d & 63;
    else if (a == 63) mrate = d;
  endfunction

  task automatic xfer(input logic [15:0] w, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < 16; i++) begin
      @(negedge sclk_o); #1; fs_i = (i == 0); sdi_i = w[15-i];
      @(posedge sclk_o); #1; if (i > 0) r[16-i] = sdo_o;
    end
    @(negedge sclk_o); #1; fs_i = 1'b0; sdi_i = 1'b0;
    @(posedge sclk_o); #1; r[0] = sdo_o;
  endtask

  task automatic chk_regs(input string req);
    logic [79:0] e;
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 4; k++) e[(g*4+k)*10 +: 10] = 10'(mg[g][k]);
    chk(regs_o == e, req, regs_o, e);
  endtask

  // one frame: checks readout, then applies the write to the model
  task automatic frame(input int a, input int d, input string req);
    logic [15:0] r, e;
    e = {6'(mptr), 10'(mread(mptr))};
    xfer({6'(a), 10'(d)}, r);
    chk(r == e, req, r, e);
    mwrite(a, d);
    chk_regs(req);
  endtask

  task automatic period(input int exp, input string req);
    longint t0, t1;
    @(posedge sclk_o); t0 = $time;
    @(posedge sclk_o); t1 = $time;
    chk((t1 - t0) / 8 == exp, req, (t1 - t0) / 8, exp);
  endtask

  initial begin
    bit early;
    for (int g = 0; g < 2; g++) for (int k = 0; k < 4; k++) mg[g][k] = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(regs_o == '0, "R8 regs at reset", regs_o, 0);
    chk(sdo_o == 1'b0, "R8 sdo at reset", sdo_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    early = 0;
    for (int n = 1; n <= 11; n++) begin
      @(posedge clk_i); #1; if (sclk_o) early = 1;
    end
    chk(!early, "R7 sclk held low", early, 0);
    @(posedge clk_i); #1;
    chk(sclk_o == 1'b1, "R7 first sclk rise", sclk_o, 1);
    period(8, "R4 default period");

    frame(1, 'h155, "R1 write g0r1");
    frame(62, 1, "R8 pointer reset readout");
    frame(62, 1, "R3 readback g0r1");
    frame(10, 'h2AA, "R1 write g1r2");
    frame(3, 'h0F0, "R1 write g0r3");
    frame(62, 10, "R2 read g0r1");
    frame(62, 3, "R2 read g1r2");
    frame(8, 'h1FF, "R1 write g1 ctrl no clear");
    frame(62, 8, "R3 read g0r3");
    frame(5, 'h3FF, "R9 undefined write");
    frame(20, 'h123, "R9 undefined write high");
    frame(62, 5, "R2 read g1 ctrl");
    frame(62, 5, "R9 undefined reads zero");
    frame(63, 2, "R4 rate write");
    period(4, "R4 rate 2 period");
    frame(62, 63, "R4 rate 2 frame");
    frame(8, 'h201, "R5 group clear");
    frame(62, 8, "R6 rate kept after clear");
    frame(62, 10, "R5 ctrl bit reads zero");
    frame(63, 0, "R5 cleared reg reads zero");
    period(2, "R4 rate 0 as 1");
    frame(62, 1, "R4 rate 0 frame");
    frame(0, 'h200, "R6 ptr kept g0 clear");
    frame(62, 3, "R5 g0 cleared");
    frame(63, 4, "R5 g0r3 cleared");
    period(8, "R4 rate back to 4");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule